// File: doc/BRIEF.md
# Grouped Change-of-State Interrupt Controller

This block monitors a bank of 32 digital inputs arranged as four groups of eight, three general groups followed by one TTL group. It raises a single interrupt request when an input moves in a direction that software has enabled for that input's group. One 8-bit enable register does two jobs. It selects the edge direction for each group, and it masks the group when both of the group's bits are zero. Writing the register therefore changes masking and edge type together, with no separate mask register.

Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized sample with the sample taken on the previous clock. Each qualifying edge sets a sticky status bit for its group, and the interrupt output is the OR of those bits. A small register port lets software do four things: read the synchronized input levels, write and read back the enable register, read the latched status, and clear status bits by writing ones.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, the status reads 0x0 and `irq_o` is low.
- R2: Pin groups are g0 = pins 7:0, g1 = pins 15:8, g2 = pins 23:16 and g3 = pins 31:24 (the TTL group). Enable bit k (k = 0..3) lets a 0-to-1 transition on any pin of group k set status bit k.
- R3: Enable bit 4+k (k = 0..3) lets a 1-to-0 transition on any pin of group k set status bit k. A transition in a direction whose bit is clear sets nothing.
- R4: When both bits of a group are clear (k and 4+k), no transition in that group sets its status bit.
- R5: When both bits of a group are set, a transition in either direction sets that group's status bit.
- R6: Status bits are sticky. `irq_o` is high exactly while any status bit is set, and it stays high until software clears the bits.
- R7: A write to address 2 clears every status bit whose write-data bit (3:0) is 1 and leaves the other bits unchanged.
- R8: If a qualifying edge and a clear of the same status bit land on the same clock, the bit ends up set.
- R9: Writing the enable register does not change status bits that are already latched. The new value only gates edges detected afterwards.
- R10: Reads are combinational from `addr_i`. Address 0 returns the synchronized pin levels, address 1 returns the enable register in bits 7:0, address 2 returns the status in bits 3:0, and address 3 returns zero. Writes to address 1 load the enable register from bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 32 | Asynchronous digital inputs, four groups of eight |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Interrupt request, OR of the status bits |

## Verification
The hardest case to reach from the ports is R8, where a status clear and a new qualifying edge for the same group land on the same clock edge. The bench counts the register stages from pin to status: two synchronizer flops, then the compare against the previous sample. It changes a pin on a falling clock edge and issues the clearing write exactly two rising edges later, so both requests are sampled together. A read of the status afterwards must show the bit still set, and a later clear on its own must remove it.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int unsigned NUM_GROUPS  = 4;
    localparam int unsigned GROUP_WIDTH = 8;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned ADDR_W      = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LEVEL  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cos_edge_detect.sv
module cos_edge_detect #(
    parameter int unsigned NUM_GROUPS  = 4,
    parameter int unsigned GROUP_WIDTH = 8,
    localparam int unsigned PIN_W      = NUM_GROUPS * GROUP_WIDTH,
    localparam int unsigned EN_W       = 2 * NUM_GROUPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIN_W-1:0]      sync_i,
    input  logic [EN_W-1:0]       enable_i,
    output logic [NUM_GROUPS-1:0] set_o
);
    logic [PIN_W-1:0] prev_d, prev_q;

    assign prev_d = sync_i;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic [GROUP_WIDTH-1:0] cur, old;
        logic rise_any, fall_any;
        assign cur      = sync_i[g*GROUP_WIDTH +: GROUP_WIDTH];
        assign old      = prev_q[g*GROUP_WIDTH +: GROUP_WIDTH];
        assign rise_any = |(cur & ~old);
        assign fall_any = |(~cur & old);
        assign set_o[g] = (rise_any & enable_i[g]) | (fall_any & enable_i[NUM_GROUPS+g]);

        // R4: a group with both direction bits clear never requests a set
        a_r4_masked_group: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable_i[g] && !enable_i[NUM_GROUPS+g]) |-> !set_o[g]);
    end
endmodule

// File: rtl/cos_status.sv
module cos_status #(
    parameter int unsigned NUM_GROUPS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] set_i,
    input  logic [NUM_GROUPS-1:0] clr_i,
    output logic [NUM_GROUPS-1:0] status_o
);
    typedef struct packed {
        logic [NUM_GROUPS-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;

    // R6: a latched bit that is not cleared stays latched
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.bits) & ~$past(clr_i)) & ~st_q.bits) == '0));
    // R8: a set request always lands, even with a clear in the same cycle
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((st_q.bits & $past(set_i)) == $past(set_i)));
    // R9: bits only rise where a set was requested
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.bits & ~$past(st_q.bits) & ~$past(set_i)) == '0));
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int unsigned GROUPS  = NUM_GROUPS,
    parameter int unsigned GWIDTH  = GROUP_WIDTH,
    parameter int unsigned NSYNC   = SYNC_STAGES,
    parameter int unsigned DWIDTH  = DATA_W,
    localparam int unsigned PIN_W  = GROUPS * GWIDTH,
    localparam int unsigned EN_W   = 2 * GROUPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pins_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DWIDTH-1:0] wdata_i,
    output logic [DWIDTH-1:0] rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [EN_W-1:0] enable;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PIN_W-1:0]  level;
    logic [GROUPS-1:0] set_req, clr_req, status;

    cos_sync #(.WIDTH(PIN_W), .STAGES(NSYNC)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pins_i),
        .sync_o (level)
    );

    cos_edge_detect #(.NUM_GROUPS(GROUPS), .GROUP_WIDTH(GWIDTH)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (level),
        .enable_i(ctl_q.enable),
        .set_o   (set_req)
    );

    cos_status #(.NUM_GROUPS(GROUPS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_req),
        .clr_i   (clr_req),
        .status_o(status)
    );

    always_comb begin
        ctl_d   = ctl_q;
        clr_req = '0;
        if (wr_en_i && addr_i == REG_ENABLE) ctl_d.enable = wdata_i[EN_W-1:0];
        if (wr_en_i && addr_i == REG_STATUS) clr_req      = wdata_i[GROUPS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_LEVEL:  rdata_o[PIN_W-1:0]  = level;
            REG_ENABLE: rdata_o[EN_W-1:0]   = ctl_q.enable;
            REG_STATUS: rdata_o[GROUPS-1:0] = status;
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = |status;

    // R6: the request only rises after an edge was qualified
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(set_req) != '0));
    // R1: the cycle after reset the enable register is empty
    a_r1_reset_enable: assert property (@(posedge clk)
        !rst_n |=> (ctl_q.enable == '0));
endmodule

// File: tb/cos_irq_ctrl_test.sv
`timescale 1ns/1ps
module cos_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cos_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    // {enable[7:0], pins_from[31:0], pins_to[31:0], status_expected[3:0]}
    localparam int NV = 10;
    localparam logic [75:0] VEC [NV] = '{
        {8'h01, 32'h0000_0000, 32'h0000_0001, 4'b0001}, // R2 rise g0
        {8'h01, 32'h0000_0001, 32'h0000_0000, 4'b0000}, // R3 fall not enabled
        {8'h10, 32'h0000_0001, 32'h0000_0000, 4'b0001}, // R3 fall g0
        {8'h00, 32'h0000_0000, 32'hFFFF_FFFF, 4'b0000}, // R4 all masked
        {8'hFF, 32'h0000_0000, 32'h0101_0101, 4'b1111}, // R5 all groups rise
        {8'h88, 32'hFF00_0000, 32'h0000_0000, 4'b1000}, // R5 g3 fall with both
        {8'h22, 32'h0000_0000, 32'h0000_8000, 4'b0010}, // R2 g1 rise top pin
        {8'h44, 32'h00FF_0000, 32'h00FE_0000, 4'b0100}, // R3 g2 single fall
        {8'h0F, 32'h0000_FF00, 32'h00FF_0000, 4'b0100}, // R2 rise only
        {8'hF0, 32'h0000_FF00, 32'h00FF_0000, 4'b0010}  // R3 fall only
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(2'd1, v); check("R1 enable", v, 32'h0);
        rd(2'd2, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            pins = VEC[i][67:36];
            cyc(5);
            wr(2'd2, 32'hF);
            wr(2'd1, {24'h0, VEC[i][75:68]});
            pins = VEC[i][35:4];
            cyc(5);
            rd(2'd2, v);
            check($sformatf("R2/R3/R4/R5 vector %0d status", i), v, {28'h0, VEC[i][3:0]});
            check($sformatf("R6 vector %0d irq", i), {31'b0, irq}, {31'b0, |VEC[i][3:0]});
        end

        // R10 level readback and enable readback
        pins = 32'hA5C3_0F96;
        cyc(4);
        rd(2'd0, v); check("R10 level", v, 32'hA5C3_0F96);
        rd(2'd1, v); check("R10 enable readback", v, 32'h0000_00F0);
        rd(2'd3, v); check("R10 spare reads zero", v, 32'h0);

        // R6/R7 sticky and partial W1C
        wr(2'd2, 32'hF);
        wr(2'd1, 32'hFF);
        pins = 32'h5A3C_F069;
        cyc(5);
        rd(2'd2, v); check("R6 all latched", v, 32'hF);
        cyc(20);
        rd(2'd2, v); check("R6 still latched", v, 32'hF);
        wr(2'd2, 32'h5);
        rd(2'd2, v); check("R7 partial clear", v, 32'hA);
        check("R6 irq held", {31'b0, irq}, 32'h1);

        // R9 enable change keeps latched bits
        wr(2'd1, 32'h00);
        rd(2'd2, v); check("R9 status kept", v, 32'hA);
        pins = 32'h0;
        cyc(5);
        rd(2'd2, v); check("R9 masked after change", v, 32'hA);
        wr(2'd2, 32'hF);
        rd(2'd2, v); check("R7 full clear", v, 32'h0);
        check("R6 irq low after clear", {31'b0, irq}, 32'h0);

        // R8 set and clear on the same edge
        wr(2'd1, 32'h01);
        cyc(3);
        pins = 32'h1;
        cyc(2);
        addr = 2'd2; wdata = 32'h1; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        rd(2'd2, v); check("R8 set wins", v, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, v); check("R8 later clear", v, 32'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule